// File: doc/BRIEF.md
# Two-Thread Partitioned Micro-Op Queue

This block is the buffer between an instruction front end and an out-of-order back end in a core that runs two hardware threads at once. Decoded micro-ops arrive one per cycle, each tagged with the thread that produced it. The back end pulls from either thread by raising a dequeue request tagged with the thread it wants. Each thread has its own write pointer, read pointer and occupancy count, and its own full and empty flags.

The storage array is split statically according to the current operating mode. In shared mode each thread owns a fixed half of the entries. A thread that is stalled can therefore never take space from the other thread. When one thread halts, the queue can be switched into a solo mode for the surviving thread. In that mode the split disappears and the surviving thread may fill the whole array. A requested mode is taken up only once both threads' regions are empty. Until then the request is held off.

Top module: `uop_split_queue`

## Requirements
- R1: After reset the mode is shared (code 0), both empty flags are 1, both full flags are 0, the error output is 0 and no dequeue is valid.
- R2: Each thread's micro-ops leave in the same order in which that thread's enqueues were accepted.
- R3: In shared mode (mode code 0) a thread holds at most DEPTH/2 entries. Its full flag (bit t of `full`) is 1 exactly when it holds DEPTH/2 entries.
- R4: In shared mode a thread with a full region has no effect on how many entries the other thread can accept.
- R5: In solo mode (code 1 = thread 0 alone, code 2 = thread 1 alone) the active thread holds up to DEPTH entries, and its full flag rises only at DEPTH.
- R6: In solo mode the inactive thread shows full and empty both at 1. Any enqueue tagged with the inactive thread is rejected.
- R7: `mode_req` is adopted at a clock edge only when both threads hold zero entries and `enq_valid` is 0 in that cycle. Until then the request is held off. Code 3 is never adopted.
- R8: An enqueue into a full region and a dequeue from an empty region change no state. Each one raises `err` for exactly the following cycle.
- R9: An accepted enqueue and an accepted dequeue for the same thread in the same cycle leave that thread's occupancy unchanged.
- R10: `deq_valid` and `deq_data` respond in the same cycle as the request. `deq_valid` is 1 exactly when `deq_req` is 1 and the addressed region is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 2 | Requested mode: 0 shared, 1 thread 0 alone, 2 thread 1 alone |
| enq_valid | input | 1 | Enqueue strobe |
| enq_tid | input | 1 | Thread tag of the enqueue |
| enq_data | input | WIDTH | Micro-op being enqueued |
| deq_req | input | 1 | Dequeue request |
| deq_tid | input | 1 | Thread tag of the dequeue |
| deq_valid | output | 1 | Dequeue accepted this cycle |
| deq_data | output | WIDTH | Oldest micro-op of the addressed thread |
| full | output | 2 | Per-thread full flags |
| empty | output | 2 | Per-thread empty flags |
| mode | output | 2 | Mode currently in force |
| err | output | 1 | One-cycle pulse after a rejected enqueue or dequeue |

## Verification
The assertions assume that every input is at a known level from the first edge after reset. They also assume that `mode_req` may hold any code, including the unused 3, since the queue must ignore it rather than reject it. The stimulus drives every input at each falling edge from defined values. Most of the time it holds `mode_req` steady and leans towards dequeues, so that both regions drain often enough for mode changes to be taken up. Enqueues on full regions, dequeues on empty regions and enqueues tagged with the inactive thread all occur naturally within those bounds.

// File: rtl/uop_split_queue.sv
module uop_split_queue #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_req,
  input  logic             enq_valid,
  input  logic             enq_tid,
  input  logic [WIDTH-1:0] enq_data,
  input  logic             deq_req,
  input  logic             deq_tid,
  output logic             deq_valid,
  output logic [WIDTH-1:0] deq_data,
  output logic [1:0]       full,
  output logic [1:0]       empty,
  output logic [1:0]       mode,
  output logic             err
);
  localparam int AW = $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;
  localparam logic [1:0] M_SHARED = 2'd0;
  localparam logic [1:0] M_SOLO0  = 2'd1;
  localparam logic [1:0] M_SOLO1  = 2'd2;
  localparam logic [AW:0]   CAP_FULL = AW'(0) + (AW+1)'(DEPTH);
  localparam logic [AW:0]   CAP_HALF = (AW+1)'(HALF);
  localparam logic [AW-1:0] BASE_HI  = AW'(HALF);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp [2];
  logic [AW-1:0] rp [2];
  logic [AW:0]   cnt [2];
  logic [AW:0]   cap [2];
  logic [AW-1:0] base [2];
  logic [AW-1:0] lim [2];
  logic [1:0]    enq_ok, deq_ok;
  logic          switch_ok;

  assign cap[0]  = (mode == M_SHARED) ? CAP_HALF : (mode == M_SOLO0) ? CAP_FULL : '0;
  assign cap[1]  = (mode == M_SHARED) ? CAP_HALF : (mode == M_SOLO1) ? CAP_FULL : '0;
  assign base[0] = '0;
  assign base[1] = (mode == M_SHARED) ? BASE_HI : '0;

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assign lim[t]    = AW'(base[t] + cap[t][AW-1:0] - 1'b1) | ((cap[t] == CAP_FULL) ? '1 : '0);
    assign full[t]   = (cnt[t] == cap[t]);
    assign empty[t]  = (cnt[t] == '0);
    assign enq_ok[t] = enq_valid && (enq_tid == 1'(t)) && !full[t];
    assign deq_ok[t] = deq_req && (deq_tid == 1'(t)) && !empty[t];
  end

  assign switch_ok = (cnt[0] == '0) && (cnt[1] == '0) && !enq_valid &&
                     (mode_req != 2'd3) && (mode_req != mode);
  assign deq_valid = |deq_ok;
  assign deq_data  = mem[rp[deq_tid]];

  always_ff @(posedge clk) begin
    if (enq_ok != 2'b00) mem[wp[enq_tid]] <= enq_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_SHARED;
      err  <= 1'b0;
      wp[0] <= '0; rp[0] <= '0; cnt[0] <= '0;
      wp[1] <= BASE_HI; rp[1] <= BASE_HI; cnt[1] <= '0;
    end else begin
      err <= (enq_valid && full[enq_tid]) || (deq_req && empty[deq_tid]);
      if (switch_ok) begin
        mode  <= mode_req;
        wp[0] <= '0;
        rp[0] <= '0;
        wp[1] <= (mode_req == M_SHARED) ? BASE_HI : '0;
        rp[1] <= (mode_req == M_SHARED) ? BASE_HI : '0;
      end else begin
        for (int t = 0; t < 2; t++) begin
          if (enq_ok[t]) wp[t] <= (wp[t] == lim[t]) ? base[t] : wp[t] + 1'b1;
          if (deq_ok[t]) rp[t] <= (rp[t] == lim[t]) ? base[t] : rp[t] + 1'b1;
          cnt[t] <= cnt[t] + (AW+1)'(enq_ok[t]) - (AW+1)'(deq_ok[t]);
        end
      end
    end
  end

  assert_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SHARED) |-> (cnt[0] <= CAP_HALF && cnt[1] <= CAP_HALF));
  assert_cap_solo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] <= CAP_FULL && cnt[1] <= CAP_FULL));
  assert_inactive_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_SOLO0) |-> (cnt[1] == '0)) and ((mode == M_SOLO1) |-> (cnt[0] == '0)));
  assert_mode_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> ($past(empty) == 2'b11 && !$past(enq_valid)));
  assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
  assert_err_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && full[enq_tid]) |=> err);
  assert_pair_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_ok[0] && deq_ok[0] && !switch_ok) |=> (cnt[0] == $past(cnt[0])));
endmodule

// File: tb/uop_split_queue_bench.sv
module uop_split_queue_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  mode_req = 2'd0;
  logic        enq_valid = 1'b0, enq_tid = 1'b0, deq_req = 1'b0, deq_tid = 1'b0;
  logic [31:0] enq_data = '0;
  logic        deq_valid, err;
  logic [31:0] deq_data;
  logic [1:0]  full, empty, mode;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] q0[$], q1[$];
  logic [1:0]  m_mode = 2'd0;
  bit          err_exp = 0;

  always #2 clk = ~clk;

  uop_split_queue #(.DEPTH(16), .WIDTH(32)) u_uop_split_queue (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .enq_valid(enq_valid),
    .enq_tid(enq_tid), .enq_data(enq_data), .deq_req(deq_req), .deq_tid(deq_tid),
    .deq_valid(deq_valid), .deq_data(deq_data), .full(full), .empty(empty),
    .mode(mode), .err(err));

  function automatic int cap_of(logic [1:0] m, bit t);
    if (m == 2'd0) return 8;
    if (m == 2'd1) return t ? 0 : 16;
    return t ? 16 : 0;
  endfunction

  function automatic int size_of(bit t);
    return t ? q1.size() : q0.size();
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit ev, bit et, logic [31:0] ed, bit dr, bit dt, logic [1:0] mr);
    bit e_ok, d_ok;
    logic [31:0] head;
    @(negedge clk);
    enq_valid = ev; enq_tid = et; enq_data = ed; deq_req = dr; deq_tid = dt; mode_req = mr;
    #1;
    e_ok = ev && size_of(et) < cap_of(m_mode, et);
    d_ok = dr && size_of(dt) > 0;
    head = d_ok ? (dt ? q1[0] : q0[0]) : 32'h0;
    check("R10 deq_valid", {31'b0, deq_valid}, {31'b0, d_ok});
    if (d_ok) check("R2 deq_data", deq_data, head);
    for (int t = 0; t < 2; t++) begin
      check(m_mode == 2'd0 ? "R3 full" : "R5 full", {31'b0, full[t]},
            {31'b0, size_of(t[0]) == cap_of(m_mode, t[0])});
      check("R6 empty", {31'b0, empty[t]}, {31'b0, size_of(t[0]) == 0});
    end
    check("R7 mode", {30'b0, mode}, {30'b0, m_mode});
    check("R8 err", {31'b0, err}, {31'b0, err_exp});
    @(posedge clk);
    err_exp = (ev && !e_ok) || (dr && !d_ok);
    if (q0.size() == 0 && q1.size() == 0 && !ev && mr != 2'd3) m_mode = mr;
    else begin
      if (e_ok) begin if (et) q1.push_back(ed); else q0.push_back(ed); end
      if (d_ok) begin if (dt) void'(q1.pop_front()); else void'(q0.pop_front()); end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 full", {30'b0, full}, 32'd0);
    check("R1 empty", {30'b0, empty}, 32'd3);
    check("R1 mode", {30'b0, mode}, 32'd0);
    check("R1 err", {31'b0, err}, 32'd0);
    check("R1 deq_valid", {31'b0, deq_valid}, 32'd0);

    for (int i = 0; i < 8; i++) step(1, 0, 32'hA000 + i, 0, 0, 2'd0);
    #1 check("R3 thread0 full at half", {30'b0, full}, 32'd1);
    step(1, 0, 32'hDEAD, 0, 0, 2'd0);
    #1 check("R8 err after overflow", {31'b0, err}, 32'd1);
    for (int i = 0; i < 8; i++) step(1, 1, 32'hB000 + i, 0, 0, 2'd0);
    #1 check("R4 both halves full", {30'b0, full}, 32'd3);
    step(0, 0, 0, 1, 0, 2'd1);
    #1 check("R7 held while occupied", {30'b0, mode}, 32'd0);
    for (int i = 0; i < 8; i++) begin step(0, 0, 0, 1, 0, 2'd1); step(0, 0, 0, 1, 1, 2'd1); end
    step(0, 0, 0, 0, 0, 2'd1);
    #1 check("R7 adopted once drained", {30'b0, mode}, 32'd1);
    for (int i = 0; i < 15; i++) step(1, 0, 32'hC000 + i, 0, 0, 2'd1);
    #1 check("R5 not full at 15", {30'b0, full}, 32'd2);
    step(1, 0, 32'hC00F, 0, 0, 2'd1);
    #1 check("R5 full at 16", {30'b0, full}, 32'd3);
    step(1, 1, 32'hEEEE, 0, 0, 2'd1);
    #1 check("R6 inactive enqueue err", {31'b0, err}, 32'd1);
    check("R6 inactive empty", {31'b0, empty[1]}, 32'd1);
    step(0, 0, 0, 1, 0, 2'd1);
    step(1, 0, 32'hF00D, 1, 0, 2'd1);
    #1 check("R9 paired ops keep count", {30'b0, full}, 32'd2);
    for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 0, 2'd3);
    step(0, 0, 0, 0, 0, 2'd3);
    #1 check("R7 code 3 ignored", {30'b0, mode}, 32'd1);

    for (int i = 0; i < 4000; i++) begin
      logic [1:0] mr;
      mr = ($urandom % 40 == 0) ? 2'($urandom) : m_mode;
      if ($urandom % 200 == 0) mr = 2'($urandom % 3);
      step($urandom % 100 < 40, 1'($urandom), $urandom, $urandom % 100 < 55, 1'($urandom),
           (i % 300 > 250) ? mr : (($urandom % 60 == 0) ? 2'($urandom) : mode_req));
    end
    finish_run();
  end
endmodule